// File: doc/BRIEF.md
# Two-Phase Full-Frame Sensor Readout Sequencer

This block produces the digital phase pattern that empties a full-frame image sensor with a two-phase vertical register and a two-phase horizontal register. It is started by a pulse on `start`. First it holds both vertical phases low for a programmed exposure time. It then moves one line into the horizontal register and clocks that line out one pixel at a time. The line move and line readout repeat until the programmed number of lines has been emptied. A sample strobe marks the clock cycle in which each charge packet reaches the output node. The analog front end uses this strobe to take its sample.

The controller is one state machine with named states. The first is ST_IDLE. Start takes it to ST_EXPOSE. When the exposure timer ends it goes to ST_VX_A (V1 high), then ST_VX_B (V2 high), ST_VX_C (V1 high) and ST_VX_D (both low). Each of these vertical states ends when the hold timer ends. From ST_VX_D it goes to ST_H_RAISE (H2 high). ST_H_RAISE always goes on to ST_H_DROP (H2 low, strobe). From ST_H_DROP the machine goes back to ST_H_RAISE while pixels remain in the line. It goes to ST_VX_A while lines remain. After the last pixel of the last line it goes to ST_DONE, and ST_DONE always returns to ST_IDLE. Three down-counters serve the machine: one is the state-hold timer, one counts lines and one counts pixels.

Top module: `ccd_readout_seq`

## Requirements
- R1: While reset is high and in the cycle after reset, v1=0, v2=0, h1=1, h2=0, sample=0, busy=0 and done=0.
- R2: A start seen in idle raises busy in the next cycle. The block then holds v1=v2=0 for exactly expose_cfg cycles before the first line move. A value of 0 is treated as 1.
- R3: Each line move drives the pattern {v1,v2} = 10, then 01, then 10, then 00. Each of the first three patterns lasts exactly hold_cfg cycles, with 0 treated as 1. The 00 settle state also lasts hold_cfg cycles.
- R4: h1 and h2 are always complementary. While either vertical phase is high they sit at their idle levels, h1=1 and h2=0.
- R5: Each pixel is h2 high for one cycle followed by h2 low for one cycle. sample is high exactly in the cycle in which h2 has just fallen. Each line produces exactly cols_cfg strobes, with 0 treated as 1.
- R6: The block performs rows_cfg line moves, with 0 treated as 1. Each line move is followed by the full horizontal readout of that line, and no horizontal clocking happens until the line move has ended.
- R7: done is high for one cycle, in the cycle after the last pixel of the last line. busy is low in the following cycle. From the first busy cycle, busy stays high with done low for E + R*(4*H + 2*C) cycles, where E, R, H and C are the effective (clamped) exposure, row, hold and column values.
- R8: A start pulse while busy is high has no effect: the frame length is unchanged and no new frame follows the current one.
- R9: A synchronous reset in the middle of a frame returns all outputs to the R1 values in the next cycle, and a later start runs a correct frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame request, taken only in idle |
| rows_cfg | input | ROW_W | Lines per frame (0 acts as 1) |
| cols_cfg | input | COL_W | Pixels per line (0 acts as 1) |
| expose_cfg | input | EXP_W | Exposure length in cycles (0 acts as 1) |
| hold_cfg | input | HOLD_W | Cycles per vertical phase state (0 acts as 1) |
| v1 | output | 1 | Vertical phase 1 |
| v2 | output | 1 | Vertical phase 2 |
| h1 | output | 1 | Horizontal phase 1 |
| h2 | output | 1 | Horizontal phase 2 |
| sample | output | 1 | Pixel sample strobe |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The pixel-count assertion compares the strobes seen in a line against `cols_cfg` at the start of the next line and at done. It therefore assumes that the configuration inputs do not change while busy is high. The bench sets the configuration only in idle, before it raises start, and holds it until done. It fires extra start pulses only in the middle of a frame, and it asserts reset only where R9 is being tested.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EXPOSE,
        ST_VX_A,
        ST_VX_B,
        ST_VX_C,
        ST_VX_D,
        ST_H_RAISE,
        ST_H_DROP,
        ST_DONE
    } seq_state_t;

    function automatic logic is_timed(input seq_state_t s);
        return (s == ST_EXPOSE) || (s == ST_VX_A) || (s == ST_VX_B) ||
               (s == ST_VX_C) || (s == ST_VX_D);
    endfunction

endpackage

// File: rtl/ccd_down_ctr.sv
module ccd_down_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? W'(1) : load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - W'(1);
        end
    end

    assign last = (cnt == W'(1));

endmodule

// File: rtl/ccd_seq_fsm.sv
module ccd_seq_fsm
    import ccd_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic t_last,
    input  logic r_last,
    input  logic c_last,
    output logic t_load,
    output logic t_pick_exp,
    output logic r_load,
    output logic r_dec,
    output logic c_load,
    output logic c_dec,
    output logic v1,
    output logic v2,
    output logic h1,
    output logic h2,
    output logic sample,
    output logic busy,
    output logic done
);

    seq_state_t state, nstate;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nstate;
    end

    // next state and counter control
    always_comb begin
        nstate = state;
        r_load = 1'b0;
        r_dec  = 1'b0;
        c_load = 1'b0;
        c_dec  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nstate = ST_EXPOSE;
                    r_load = 1'b1;
                end
            end
            ST_EXPOSE:  if (t_last) nstate = ST_VX_A;
            ST_VX_A:    if (t_last) nstate = ST_VX_B;
            ST_VX_B:    if (t_last) nstate = ST_VX_C;
            ST_VX_C:    if (t_last) nstate = ST_VX_D;
            ST_VX_D: begin
                if (t_last) begin
                    nstate = ST_H_RAISE;
                    c_load = 1'b1;
                end
            end
            ST_H_RAISE: nstate = ST_H_DROP;
            ST_H_DROP: begin
                c_dec = 1'b1;
                if (c_last) begin
                    r_dec  = 1'b1;
                    nstate = r_last ? ST_DONE : ST_VX_A;
                end else begin
                    nstate = ST_H_RAISE;
                end
            end
            ST_DONE:    nstate = ST_IDLE;
            default:    nstate = ST_IDLE;
        endcase
        t_load     = (nstate != state) && is_timed(nstate);
        t_pick_exp = (nstate == ST_EXPOSE);
    end

    // output decode
    always_comb begin
        v1     = 1'b0;
        v2     = 1'b0;
        h1     = 1'b1;
        h2     = 1'b0;
        sample = 1'b0;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_EXPOSE:  ;
            ST_VX_A:    v1 = 1'b1;
            ST_VX_B:    v2 = 1'b1;
            ST_VX_C:    v1 = 1'b1;
            ST_VX_D:    ;
            ST_H_RAISE: begin
                h1 = 1'b0;
                h2 = 1'b1;
            end
            ST_H_DROP:  sample = 1'b1;
            ST_DONE:    done = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R7

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R8

    AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && !v1 && !v2)); // R2

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq #(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 12,
    parameter int EXP_W  = 24,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ROW_W-1:0]  rows_cfg,
    input  logic [COL_W-1:0]  cols_cfg,
    input  logic [EXP_W-1:0]  expose_cfg,
    input  logic [HOLD_W-1:0] hold_cfg,
    output logic              v1,
    output logic              v2,
    output logic              h1,
    output logic              h2,
    output logic              sample,
    output logic              busy,
    output logic              done
);

    localparam int T_W = (EXP_W > HOLD_W) ? EXP_W : HOLD_W;

    logic t_load, t_pick_exp, t_last;
    logic r_load, r_dec, r_last;
    logic c_load, c_dec, c_last;
    logic [T_W-1:0] t_val;

    assign t_val = t_pick_exp ? T_W'(expose_cfg) : T_W'(hold_cfg);

    ccd_down_ctr #(.W(T_W)) u_hold_tmr (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
        .dec(1'b1), .last(t_last)
    );

    ccd_down_ctr #(.W(ROW_W)) u_row_ctr (
        .clk(clk), .rst(rst), .load(r_load), .load_val(rows_cfg),
        .dec(r_dec), .last(r_last)
    );

    ccd_down_ctr #(.W(COL_W)) u_col_ctr (
        .clk(clk), .rst(rst), .load(c_load), .load_val(cols_cfg),
        .dec(c_dec), .last(c_last)
    );

    ccd_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start),
        .t_last(t_last), .r_last(r_last), .c_last(c_last),
        .t_load(t_load), .t_pick_exp(t_pick_exp),
        .r_load(r_load), .r_dec(r_dec), .c_load(c_load), .c_dec(c_dec),
        .v1(v1), .v2(v2), .h1(h1), .h2(h2),
        .sample(sample), .busy(busy), .done(done)
    );

    // strobes per line, observed at the ports for the checks below
    logic             v1_q, v2_q;
    logic [COL_W:0]   pix_seen;
    logic [COL_W:0]   cols_eff;
    logic             line_start;

    assign cols_eff   = (cols_cfg == '0) ? (COL_W+1)'(1) : {1'b0, cols_cfg};
    assign line_start = v1 && !v1_q && !v2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q     <= 1'b0;
            v2_q     <= 1'b0;
            pix_seen <= '0;
        end else begin
            v1_q <= v1;
            v2_q <= v2;
            if (!busy || line_start) pix_seen <= '0;
            else if (sample)         pix_seen <= pix_seen + 1'b1;
        end
    end

    AST_V2_AFTER_V1: assert property (@(posedge clk) disable iff (rst)
        $rose(v2) |-> ($past(v1) && !v1)); // R3

    AST_V2_FALL_TO_V1: assert property (@(posedge clk) disable iff (rst)
        $fell(v2) |-> (v1 && !v2)); // R3

    AST_H_IDLE_IN_VX: assert property (@(posedge clk) disable iff (rst)
        (v1 || v2) |-> (h1 && !h2)); // R4

    AST_SAMPLE_EDGE: assert property (@(posedge clk) disable iff (rst)
        sample |-> $fell(h2)); // R5

    AST_COL_COUNT: assert property (@(posedge clk) disable iff (rst)
        (line_start && busy && pix_seen != '0) |-> (pix_seen == cols_eff)); // R5

    AST_LAST_LINE_COLS: assert property (@(posedge clk) disable iff (rst)
        done |-> (pix_seen == cols_eff)); // R6

endmodule

// File: tb/ccd_readout_seq_tb_top.sv
module ccd_readout_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] rows_cfg = '0;
    logic [11:0] cols_cfg = '0;
    logic [23:0] expose_cfg = '0;
    logic [7:0]  hold_cfg = '0;
    logic v1, v2, h1, h2, sample, busy, done;

    always #4 clk = ~clk; // 125 MHz

    ccd_readout_seq dut_i (
        .clk(clk), .rst(rst), .start(start),
        .rows_cfg(rows_cfg), .cols_cfg(cols_cfg),
        .expose_cfg(expose_cfg), .hold_cfg(hold_cfg),
        .v1(v1), .v2(v2), .h1(h1), .h2(h2),
        .sample(sample), .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // port monitor
    bit mon_on = 1'b0;
    int hold_exp = 1, cols_exp = 1;
    int n_busy, n_samp, n_line, n_exp, samp_err, h_err, seq_err, hold_err, col_err;
    int run_len, vidx, line_pix;
    logic [1:0] prev_v;
    logic prev_h2;

    always @(negedge clk) begin
        logic [1:0] cur;
        logic [1:0] want;
        cur = {v1, v2};
        if (!mon_on) begin
            n_busy = 0; n_samp = 0; n_line = 0; n_exp = 0;
            samp_err = 0; h_err = 0; seq_err = 0; hold_err = 0; col_err = 0;
            run_len = 0; vidx = 0; line_pix = 0;
            prev_v = 2'b00; prev_h2 = 1'b0;
        end else begin
            if (busy && !done) n_busy++;
            if (busy && !done && n_line == 0 && cur == 2'b00) n_exp++;
            if (sample) begin
                n_samp++;
                line_pix++;
                if (!(prev_h2 && !h2)) samp_err++;
            end
            if (h1 == h2) h_err++;
            if (cur != 2'b00 && !(h1 && !h2)) h_err++;
            if (cur != prev_v) begin
                case (vidx)
                    0: want = 2'b10;
                    1: want = 2'b01;
                    2: want = 2'b10;
                    default: want = 2'b00;
                endcase
                if (cur != want) seq_err++;
                if (prev_v != 2'b00 && run_len != hold_exp) hold_err++;
                if (vidx == 0) begin
                    if (n_line > 0 && line_pix != cols_exp) col_err++;
                    if (n_line > 0 && line_pix == cols_exp) line_pix = 0;
                    n_line++;
                    line_pix = 0;
                end
                vidx = (vidx + 1) % 4;
                run_len = 1;
            end else begin
                run_len++;
            end
            prev_v = cur;
            prev_h2 = h2;
        end
    end

    typedef struct packed {
        int rows;
        int cols;
        int expo;
        int hold;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{rows: 1, cols: 1, expo: 1,  hold: 1},
        '{rows: 2, cols: 3, expo: 4,  hold: 1},
        '{rows: 3, cols: 2, expo: 2,  hold: 3},
        '{rows: 0, cols: 0, expo: 0,  hold: 0},
        '{rows: 4, cols: 5, expo: 10, hold: 2},
        '{rows: 2, cols: 7, expo: 3,  hold: 4}
    };

    function automatic int clamp1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic run_frame(input int r, input int c, input int e, input int h,
                             input bit poke);
        int re, ce, ee, he, len, waited;
        int g_busy, g_samp, g_line, g_exp, g_serr, g_herr, g_seq, g_hold, g_col, g_pix;
        re = clamp1(r); ce = clamp1(c); ee = clamp1(e); he = clamp1(h);
        len = ee + re * (4 * he + 2 * ce);
        @(negedge clk);
        rows_cfg = 12'(r); cols_cfg = 12'(c); expose_cfg = 24'(e); hold_cfg = 8'(h);
        hold_exp = he; cols_exp = ce;
        start = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_eq("R2 busy after start", int'(busy), 1);
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 3) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        chk_eq("R7 done reached", int'(done), 1);
        @(posedge clk);
        mon_on = 1'b0;
        g_busy = n_busy; g_samp = n_samp; g_line = n_line; g_exp = n_exp;
        g_serr = samp_err; g_herr = h_err; g_seq = seq_err; g_hold = hold_err;
        g_col = col_err; g_pix = line_pix;
        @(negedge clk);
        chk_eq("R7 done one cycle", int'(done), 0);
        chk_eq("R7 busy low after done", int'(busy), 0);
        @(negedge clk);
        chk_eq("R8 no restart", int'(busy), 0);
        chk_eq("R7 frame length", g_busy, len);
        chk_eq("R2 exposure cycles", g_exp, ee);
        chk_eq("R3 phase order errors", g_seq, 0);
        chk_eq("R3 hold length errors", g_hold, 0);
        chk_eq("R4 horizontal level errors", g_herr, 0);
        chk_eq("R5 strobe timing errors", g_serr, 0);
        chk_eq("R5 total strobes", g_samp, re * ce);
        chk_eq("R6 line moves", g_line, re);
        chk_eq("R6 strobes per line", g_col, 0);
        chk_eq("R6 last line strobes", g_pix, ce);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk_eq("R1 v1 in reset", int'(v1), 0);
        chk_eq("R1 h1 in reset", int'(h1), 1);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1 after reset", int'({v1, v2, h1, h2, sample, busy, done}), 7'b0010000);

        // table walk; every other frame gets a start pulse while busy (R8)
        for (int i = 0; i < NVEC; i++) begin
            run_frame(VECS[i].rows, VECS[i].cols, VECS[i].expo, VECS[i].hold, (i % 2) == 1);
        end

        // R9: reset in the middle of a frame
        @(negedge clk);
        rows_cfg = 12'd3; cols_cfg = 12'd4; expose_cfg = 24'd2; hold_cfg = 8'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk_eq("R9 outputs after mid-frame reset",
               int'({v1, v2, h1, h2, sample, busy, done}), 7'b0010000);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R9 stays idle", int'(busy), 0);
        run_frame(2, 2, 1, 1, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule